// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block sits between a processor and a slower word-wide main memory. It holds 512 twelve-bit words as 64 lines of 8 words. Each line carries a 6-bit tag and a valid bit. The processor presents a 15-bit word address, a read/write flag and write data. It holds the request until the controller answers with a one-cycle ready pulse.

A read that finds its line valid with a matching tag is answered from the cache one cycle after it is accepted. A read that misses stalls the processor. The controller then fetches the whole 8-word block from main memory, lowest offset first, stores each word, installs the new tag, marks the line valid and returns the requested word. Every write goes straight through to main memory. A write that hits also updates the cached copy, and a write that misses leaves the cache untouched.

Main memory is reached through a level request with a one-cycle acknowledge and any latency. Two counters record read hits and read misses, so a scripted access sequence can be scored for its hit ratio. A flush input empties the cache.

Top module: `dmc_cache_ctrl`

## Requirements
- R1: The address splits into tag = addr[14:9], line = addr[8:3] and word offset = addr[2:0]. Two addresses that share a line but differ in tag map to the same storage.
- R2: After a synchronous active-low reset, cpu_ready and mem_req are low, both counters read zero and every line is invalid, so the next read misses.
- R3: On a read miss, mem_req rises with mem_we low and fetches addresses {tag, line, 0} through {tag, line, 7} in increasing offset order. Each address is held stable until mem_ack. The requested word is then returned with cpu_ready.
- R4: A read hit returns the cached word with cpu_ready high in the cycle after acceptance and causes no main-memory transfer.
- R5: A read whose line is valid but whose stored tag differs is a miss. The refill replaces the line, so a later read of the evicted block misses again.
- R6: Every write produces exactly one main-memory write (mem_we high) carrying the processor's address and data. cpu_ready follows the acknowledge.
- R7: A write hit updates the cached word, so a following read hit returns the new data. A write miss does not allocate, so a following read of that address misses and returns the written data from memory.
- R8: A flush_req seen while the controller is idle clears all valid bits in one cycle. Every subsequent read misses until refilled.
- R9: hit_count rises by one per read hit and miss_count by one per read miss. Writes change neither, and the two never change in the same cycle.
- R10: cpu_ready is a single-cycle pulse and is never high while mem_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush_req | input | 1 | Invalidate every line (acted on when idle) |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 15 | Processor word address |
| cpu_wdata | input | 12 | Processor write data |
| cpu_rdata | output | 12 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Main-memory request, held until mem_ack |
| mem_we | output | 1 | Main-memory write flag |
| mem_addr | output | 15 | Main-memory word address |
| mem_wdata | output | 12 | Main-memory write data |
| mem_rdata | input | 12 | Main-memory read data, valid with mem_ack |
| mem_ack | input | 1 | Main-memory one-cycle acknowledge |
| hit_count | output | 16 | Read hits since reset |
| miss_count | output | 16 | Read misses since reset |

## Verification
The bench first reads two addresses that share a line but carry different tags. A controller that compared only the index would then return stale data and undercount misses. It logs every refill address, which catches a fill that skips, repeats or reorders offsets, or that takes the wrong block base. Writes are checked both as hits and as misses: a design that failed to update the cached word would return old data on the next hit, and one that allocated on a write miss would report a hit. Flush and a mid-run reset must both force a re-fetch of a block that was hitting, which exposes valid bits that survive either event.

// File: rtl/dmc_pkg.sv
// Shared types for the direct-mapped cache controller.
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2,
        ST_RESP  = 2'd3
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
// Tag and valid storage, one entry per cache line, with a single lookup port.
// Assumes set, invalidate and clear-all are never requested in the same cycle
// for conflicting purposes; clear-all wins over everything.
module dmc_tag_store #(
    parameter int LINE_W = 6,
    parameter int TAG_W  = 6,
    localparam int LINES = 1 << LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              inv_en,
    input  logic              set_en,
    input  logic [LINE_W-1:0] upd_line,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic [LINE_W-1:0] look_line,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              look_hit
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // One valid flop per line: reset/flush clear, refill start clears, refill end sets.
    for (genvar i = 0; i < LINES; i++) begin : g_valid
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                valid_q[i] <= 1'b0;
            end else if (inv_en && upd_line == LINE_W'(i)) begin
                valid_q[i] <= 1'b0;
            end else if (set_en && upd_line == LINE_W'(i)) begin
                valid_q[i] <= 1'b1;
            end
        end
    end

    // Tag array write at the end of a refill.
    always_ff @(posedge clk) begin
        if (set_en) begin
            tag_q[upd_line] <= set_tag;
        end
    end

    // Lookup: entry selected by line, then the stored tag compared.
    always_comb begin
        look_hit = valid_q[look_line] && (tag_q[look_line] == look_tag);
    end
endmodule

// File: rtl/dmc_data_store.sv
// Cache word storage: one write port, one asynchronous read port.
// Assumes the contents are meaningful only where the tag store says valid.
module dmc_data_store #(
    parameter int IDX_W  = 9,
    parameter int DATA_W = 12,
    localparam int WORDS = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [WORDS];

    // Word write from a refill beat or a write hit.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Read port feeding the hit path.
    always_comb begin
        rdata = mem_q[raddr];
    end
endmodule

// File: rtl/dmc_evt_ctr.sv
// Event counter that wraps on overflow, cleared by reset.
module dmc_evt_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Count one per cycle in which inc is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/dmc_ctrl_fsm.sv
// Request sequencer: accepts a processor access when idle, answers hits
// directly, refills a whole block on a read miss (offset 0 upward), and
// passes every write through to main memory.
// Assumes the processor holds its request until cpu_ready and the memory
// acknowledges each request with a single-cycle mem_ack.
module dmc_ctrl_fsm
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 12,
    parameter int LINE_W = 6,
    parameter int OFFS_W = 3,
    localparam int IDX_W = LINE_W + OFFS_W,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_req,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              look_hit,
    input  logic [DATA_W-1:0] hit_word,
    output logic              ds_we,
    output logic [IDX_W-1:0]  ds_waddr,
    output logic [DATA_W-1:0] ds_wdata,
    output logic              ts_clr,
    output logic              ts_inv,
    output logic              ts_set,
    output logic [LINE_W-1:0] ts_line,
    output logic [TAG_W-1:0]  ts_tag,
    output logic              hit_pulse,
    output logic              miss_pulse
);
    dmc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic [OFFS_W-1:0] fill_off_q;
    logic [DATA_W-1:0] rdata_q;

    logic              accept;
    logic [TAG_W-1:0]  req_tag;
    logic [LINE_W-1:0] req_line;
    logic [OFFS_W-1:0] req_off;
    logic              last_beat;

    // Field split of the captured request.
    always_comb begin
        req_tag   = req_addr_q[ADDR_W-1:IDX_W];
        req_line  = req_addr_q[IDX_W-1:OFFS_W];
        req_off   = req_addr_q[OFFS_W-1:0];
        accept    = (state_q == ST_IDLE) && !flush_req && cpu_req;
        last_beat = (fill_off_q == {OFFS_W{1'b1}});
    end

    // Next-state choice.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cpu_we)        state_d = ST_WRITE;
                    else if (look_hit) state_d = ST_RESP;
                    else               state_d = ST_FILL;
                end
            end
            ST_FILL:  if (mem_ack && last_beat) state_d = ST_RESP;
            ST_WRITE: if (mem_ack) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State, captured request, refill offset and returned word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            fill_off_q  <= '0;
            rdata_q     <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                req_addr_q  <= cpu_addr;
                req_wdata_q <= cpu_wdata;
                fill_off_q  <= '0;
                if (!cpu_we && look_hit) begin
                    rdata_q <= hit_word;
                end
            end
            if (state_q == ST_FILL && mem_ack) begin
                fill_off_q <= fill_off_q + 1'b1;
                if (fill_off_q == req_off) begin
                    rdata_q <= mem_rdata;
                end
            end
        end
    end

    // Memory-side drive, derived from the state and captured request.
    always_comb begin
        mem_req   = (state_q == ST_FILL) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = (state_q == ST_WRITE) ? req_addr_q : {req_tag, req_line, fill_off_q};
        mem_wdata = req_wdata_q;
        cpu_ready = (state_q == ST_RESP);
        cpu_rdata = rdata_q;
    end

    // Storage updates and event pulses.
    always_comb begin
        ds_we      = 1'b0;
        ds_waddr   = cpu_addr[IDX_W-1:0];
        ds_wdata   = cpu_wdata;
        ts_clr     = (state_q == ST_IDLE) && flush_req;
        ts_inv     = accept && !cpu_we && !look_hit;
        ts_set     = (state_q == ST_FILL) && mem_ack && last_beat;
        ts_line    = (state_q == ST_IDLE) ? cpu_addr[IDX_W-1:OFFS_W] : req_line;
        ts_tag     = req_tag;
        hit_pulse  = accept && !cpu_we && look_hit;
        miss_pulse = ts_inv;
        if (accept && cpu_we && look_hit) begin
            ds_we = 1'b1;
        end else if (state_q == ST_FILL && mem_ack) begin
            ds_we    = 1'b1;
            ds_waddr = {req_line, fill_off_q};
            ds_wdata = mem_rdata;
        end
    end
endmodule

// File: rtl/dmc_cache_ctrl.sv
// Direct-mapped, write-through, no-write-allocate cache controller.
// Assumes a word-addressed processor and a word-wide main memory with a
// request/acknowledge handshake of any latency.
module dmc_cache_ctrl #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 12,
    parameter int LINE_W = 6,
    parameter int OFFS_W = 3,
    parameter int CNT_W  = 16,
    localparam int IDX_W = LINE_W + OFFS_W,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_req,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    logic              look_hit;
    logic [DATA_W-1:0] hit_word;
    logic              ds_we;
    logic [IDX_W-1:0]  ds_waddr;
    logic [DATA_W-1:0] ds_wdata;
    logic              ts_clr, ts_inv, ts_set;
    logic [LINE_W-1:0] ts_line;
    logic [TAG_W-1:0]  ts_tag;
    logic              hit_pulse, miss_pulse;

    dmc_tag_store #(.LINE_W(LINE_W), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (ts_clr),
        .inv_en    (ts_inv),
        .set_en    (ts_set),
        .upd_line  (ts_line),
        .set_tag   (ts_tag),
        .look_line (cpu_addr[IDX_W-1:OFFS_W]),
        .look_tag  (cpu_addr[ADDR_W-1:IDX_W]),
        .look_hit  (look_hit)
    );

    dmc_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
        .clk   (clk),
        .we    (ds_we),
        .waddr (ds_waddr),
        .wdata (ds_wdata),
        .raddr (cpu_addr[IDX_W-1:0]),
        .rdata (hit_word)
    );

    dmc_ctrl_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W), .OFFS_W(OFFS_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_req  (flush_req),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .cpu_ready  (cpu_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack),
        .look_hit   (look_hit),
        .hit_word   (hit_word),
        .ds_we      (ds_we),
        .ds_waddr   (ds_waddr),
        .ds_wdata   (ds_wdata),
        .ts_clr     (ts_clr),
        .ts_inv     (ts_inv),
        .ts_set     (ts_set),
        .ts_line    (ts_line),
        .ts_tag     (ts_tag),
        .hit_pulse  (hit_pulse),
        .miss_pulse (miss_pulse)
    );

    dmc_evt_ctr #(.CNT_W(CNT_W)) u_hit_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (hit_pulse),
        .count (hit_count)
    );

    dmc_evt_ctr #(.CNT_W(CNT_W)) u_miss_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (miss_pulse),
        .count (miss_count)
    );
endmodule

// File: rtl/dmc_cache_chk.sv
// Port-level protocol checks for dmc_cache_ctrl, attached by bind.
module dmc_cache_chk #(
    parameter int ADDR_W = 15,
    parameter int OFFS_W = 3,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count
);
    // R2: the cycle after reset is quiet with cleared counters.
    a_r2_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!cpu_ready && !mem_req && hit_count == '0 && miss_count == '0));

    // R3: a pending memory request holds its address and direction.
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3: refill beats step through offsets in increasing order within one block.
    a_r3_fill_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we && mem_addr[OFFS_W-1:0] != {OFFS_W{1'b1}})
        |=> (mem_req && !mem_we
             && mem_addr[OFFS_W-1:0] == OFFS_W'($past(mem_addr[OFFS_W-1:0]) + 1'b1)
             && mem_addr[ADDR_W-1:OFFS_W] == $past(mem_addr[ADDR_W-1:OFFS_W])));

    // R9: each counter moves by at most one per cycle.
    a_r9_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count == $past(hit_count) || hit_count == $past(hit_count) + 1'b1));
    a_r9_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count == $past(miss_count) || miss_count == $past(miss_count) + 1'b1));

    // R9: a single access is never counted as both hit and miss.
    a_r9_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_count != $past(hit_count) && miss_count != $past(miss_count)));

    // R10: ready is a one-cycle pulse.
    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R10: ready never overlaps an outstanding memory request.
    a_r10_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);
endmodule

bind dmc_cache_ctrl dmc_cache_chk #(
    .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_ready  (cpu_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/dmc_cache_ctrl_test.sv
module dmc_cache_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_req = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic [11:0] cpu_wdata = '0;
    logic [11:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [14:0] mem_addr;
    logic [11:0] mem_wdata;
    logic [11:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [15:0] hit_count, miss_count;

    int checks = 0;
    int errors = 0;
    int nrd = 0;
    int nwr = 0;
    int wcnt = 0;
    logic [14:0] rlog [8];
    logic [11:0] mem_w [int];

    always #4 clk = ~clk;

    dmc_cache_ctrl uut (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    // Main-memory contents: written words, else a fixed function of the address.
    function automatic logic [11:0] mem_val(input logic [14:0] a);
        if (mem_w.exists(int'(a))) return mem_w[int'(a)];
        return 12'(32'(a) * 13 + 7);
    endfunction

    // Memory model: acknowledge after 1 to 4 cycles depending on the address.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt <= 0;
        end else if (mem_req && !mem_ack) begin
            if (wcnt >= int'(mem_addr[1:0])) begin
                mem_ack <= 1'b1;
                wcnt <= 0;
                if (mem_we) begin
                    mem_w[int'(mem_addr)] = mem_wdata;
                    nwr = nwr + 1;
                end else begin
                    mem_rdata <= mem_val(mem_addr);
                    rlog[nrd % 8] = mem_addr;
                    nrd = nrd + 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [14:0] a, input logic [11:0] wd,
                          output logic [11:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ready && cyc < 500);
        rd = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    // kind: 0 read expected to miss, 1 read expected to hit, 2 write
    typedef struct packed {
        logic [1:0]  kind;
        logic [14:0] addr;
        logic [11:0] wdata;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 15'h0012, 12'h000},  // R2 empty cache misses
        '{2'd1, 15'h0015, 12'h000},  // R4 same block hits
        '{2'd1, 15'h0017, 12'h000},  // R4
        '{2'd0, 15'h0210, 12'h000},  // R1 R5 same line, other tag
        '{2'd0, 15'h0012, 12'h000},  // R5 evicted block misses
        '{2'd2, 15'h0013, 12'hABC},  // R6 R7 write hit
        '{2'd1, 15'h0013, 12'h000},  // R7 sees new data
        '{2'd2, 15'h4000, 12'h123},  // R7 write miss
        '{2'd0, 15'h4000, 12'h000},  // R7 no allocate
        '{2'd0, 15'h7FFF, 12'h000},  // R1 top line
        '{2'd1, 15'h7FF8, 12'h000},  // R4
        '{2'd1, 15'h4007, 12'h000}   // R4
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] rd;
        int cyc, h0, m0, r0, w0;
        repeat (3) @(negedge clk);
        chk("R2", "ready in reset", 32'(cpu_ready), 0);
        chk("R2", "mem_req in reset", 32'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "hit_count", 32'(hit_count), 0);
        chk("R2", "miss_count", 32'(miss_count), 0);

        for (int i = 0; i < NV; i++) begin
            h0 = int'(hit_count); m0 = int'(miss_count); r0 = nrd; w0 = nwr;
            access(VECS[i].kind == 2'd2, VECS[i].addr, VECS[i].wdata, rd, cyc);
            if (VECS[i].kind == 2'd2) begin
                chk("R6", "mem writes", 32'(nwr - w0), 1);
                chk("R6", "written data", 32'(mem_val(VECS[i].addr)), 32'(VECS[i].wdata));
                chk("R9", "hits on write", 32'(int'(hit_count) - h0), 0);
                chk("R9", "misses on write", 32'(int'(miss_count) - m0), 0);
            end else begin
                chk("R3", "read data", 32'(rd), 32'(mem_val(VECS[i].addr)));
                if (VECS[i].kind == 2'd1) begin
                    chk("R4", "hit latency", 32'(cyc), 1);
                    chk("R4", "mem reads on hit", 32'(nrd - r0), 0);
                    chk("R9", "hit_count step", 32'(int'(hit_count) - h0), 1);
                end else begin
                    chk("R3", "refill beats", 32'(nrd - r0), 8);
                    chk("R9", "miss_count step", 32'(int'(miss_count) - m0), 1);
                    for (int k = 0; k < 8; k++)
                        chk("R3", "refill order", 32'(rlog[(r0 + k) % 8]),
                            32'({VECS[i].addr[14:3], 3'(k)}));
                end
            end
        end

        // R8: flush empties a line that was hitting.
        @(negedge clk); flush_req = 1'b1;
        @(negedge clk); flush_req = 1'b0;
        m0 = int'(miss_count); r0 = nrd;
        access(1'b0, 15'h7FF8, 12'h0, rd, cyc);
        chk("R8", "miss after flush", 32'(int'(miss_count) - m0), 1);
        chk("R8", "refill after flush", 32'(nrd - r0), 8);
        chk("R8", "data after flush", 32'(rd), 32'(mem_val(15'h7FF8)));

        // R2: a mid-run reset clears counters and valid bits.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "hit_count after reset", 32'(hit_count), 0);
        chk("R2", "miss_count after reset", 32'(miss_count), 0);
        access(1'b0, 15'h7FF8, 12'h0, rd, cyc);
        chk("R2", "miss after reset", 32'(miss_count), 1);
        chk("R10", "ready pulse width", 32'(cpu_ready), 1);
        @(negedge clk);
        chk("R10", "ready dropped", 32'(cpu_ready), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule